// File: doc/BRIEF.md
# Dual-Issue Slot Pairing Gate

This block sits between instruction fetch and the two issue ports of a small in-order core. Fetch hands it a 64-bit packet holding two 32-bit instructions. The low half is the left slot and the high half is the right slot. Each cycle the block decodes the class and the three register fields of both instructions. It then decides whether zero, one or two instructions go out.

The slots are not interchangeable. The left port takes integer, load and store work. The right port takes only floating-point arithmetic, and only in a cycle when the left port also issues. A loaded value is usable two instruction groups later. Because of this, the block keeps a one-entry record of the destination of a load issued in the previous cycle. The record blocks any consumer of that register for one cycle.

When only the left instruction of a packet can go, the block does not take the packet. The packet stays on the input, and in the next cycle the leftover right instruction issues by itself through the left port. The packet is taken in that cycle. The fetch interface is valid/ready:
- Fetch must hold the packet stable while `pkt_valid` is high and `pkt_ready` is low.
- A packet transfers on a clock edge where both are high.
- `pkt_ready` is never high without `pkt_valid`.

Top module: `dual_slot_issue_gate`

## Requirements
- R1: After reset no instruction is issued while no packet is offered, the load record is empty and no leftover instruction is pending.
- R2: Instruction fields are fixed as follows:
  - Bits [31:30] give the class: 00 integer, 01 load, 10 store, 11 FP arithmetic.
  - For loads and stores, bit 29 set means the data register is in the FP file.
  - Destination is [25:21], first source [20:16], second source [15:11].
  - Integer ops write rd and read rs1 and rs2, all in the integer file.
  - Loads write rd (file chosen by bit 29) and read integer rs1.
  - Stores read integer rs1, and rs2 in the file chosen by bit 29.
  - FP ops write FP rd and read FP rs1 and rs2.
  - Registers in different files never conflict.
- R3: A packet whose left instruction is not FP arithmetic and whose right instruction is FP arithmetic, with no hazard, issues both instructions and is taken in the same cycle.
- R4: The right instruction never issues in a cycle when the left one does not. If the left instruction is blocked, nothing issues and the packet is not taken.
- R5: If the left instruction is FP arithmetic or the right one is not, only the left issues. In the next cycle the right instruction is offered alone on the left port, and the packet is taken when it issues.
- R6: The pair is split (left only) when the right instruction reads the left instruction's destination, or writes the same register.
- R7: An instruction that reads the destination of a load issued in the previous cycle does not issue in this cycle. This applies to an instruction in either slot or a leftover. The record covers exactly one cycle.
- R8: An FP-file load in the left slot pairs with an independent FP arithmetic op in the right slot.
- R9: Nothing issues and `pkt_ready` stays low while `pkt_valid` is low. `fetch_hold` equals `pkt_valid` and not `pkt_ready`.
- R10: A store writes no register, so a right-slot FP op that reads the register number in the store's rd field may still pair with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | Fetch offers a packet |
| pkt_ready | output | 1 | Packet is taken at this edge |
| pkt_data | input | 64 | Left instruction in [31:0], right in [63:32] |
| fetch_hold | output | 1 | Fetch must keep the current packet |
| left_go | output | 1 | Left issue port carries an instruction |
| left_instr | output | 32 | Instruction on the left issue port |
| right_go | output | 1 | Right issue port carries an instruction |
| right_instr | output | 32 | Instruction on the right issue port |

## Verification
The interesting collision is a load-use block falling in the same cycle as a pairing decision. Two cases provoke it:
- A load paired in one packet, followed by a packet whose right instruction reads the loaded register.
- A same-packet dependence on a load, which holds the leftover exactly when the load record still names its source.

The bench drives directed sequences with hand-worked cycle-by-cycle outcomes. It then runs long random streams over a four-register subset so that hazards are frequent. Both are judged against a reference model of the pairing rules, written in the bench, that tracks its own leftover flag and load record.

// File: rtl/pairing_pkg.sv
package pairing_pkg;
  localparam int INSTR_W   = 32;
  localparam int NUM_SLOTS = 2;
  localparam int PKT_W     = INSTR_W * NUM_SLOTS;
  localparam int RIDX_W    = 5;
  localparam int CLS_LO    = 30;
  localparam int FPF_BIT   = 29;
  localparam int RD_LO     = 21;
  localparam int RS1_LO    = 16;
  localparam int RS2_LO    = 11;

  typedef enum logic [1:0] {
    CLS_INT   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_FPOP  = 2'b11
  } iclass_e;

  typedef struct packed {
    logic              vld;
    logic              fp;
    logic [RIDX_W-1:0] idx;
  } reg_ref_t;

  typedef struct packed {
    iclass_e  cls;
    reg_ref_t dst;
    reg_ref_t src1;
    reg_ref_t src2;
  } decoded_t;

  function automatic logic same_reg(reg_ref_t a, reg_ref_t b);
    return a.vld && b.vld && (a.fp == b.fp) && (a.idx == b.idx);
  endfunction

  function automatic logic reads_reg(decoded_t d, reg_ref_t r);
    return same_reg(d.src1, r) || same_reg(d.src2, r);
  endfunction
endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import pairing_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decoded_t           dec
);
  logic [RIDX_W-1:0] f_rd, f_rs1, f_rs2;
  logic              data_fp;
  iclass_e           cls;
  logic              spare_bits_unused;

  assign f_rd    = instr[RD_LO  +: RIDX_W];
  assign f_rs1   = instr[RS1_LO +: RIDX_W];
  assign f_rs2   = instr[RS2_LO +: RIDX_W];
  assign data_fp = instr[FPF_BIT];
  assign cls     = iclass_e'(instr[CLS_LO +: 2]);
  assign spare_bits_unused = ^{instr[FPF_BIT-1:RD_LO+RIDX_W], instr[RS2_LO-1:0]};

  always_comb begin
    dec      = '0;
    dec.cls  = cls;
    unique case (cls)
      CLS_INT: begin
        dec.dst  = '{vld: 1'b1, fp: 1'b0, idx: f_rd};
        dec.src1 = '{vld: 1'b1, fp: 1'b0, idx: f_rs1};
        dec.src2 = '{vld: 1'b1, fp: 1'b0, idx: f_rs2};
      end
      CLS_LOAD: begin
        dec.dst  = '{vld: 1'b1, fp: data_fp, idx: f_rd};
        dec.src1 = '{vld: 1'b1, fp: 1'b0, idx: f_rs1};
      end
      CLS_STORE: begin
        dec.src1 = '{vld: 1'b1, fp: 1'b0, idx: f_rs1};
        dec.src2 = '{vld: 1'b1, fp: data_fp, idx: f_rs2};
      end
      default: begin
        dec.dst  = '{vld: 1'b1, fp: 1'b1, idx: f_rd};
        dec.src1 = '{vld: 1'b1, fp: 1'b1, idx: f_rs1};
        dec.src2 = '{vld: 1'b1, fp: 1'b1, idx: f_rs2};
      end
    endcase
  end
endmodule

// File: rtl/load_tracker.sv
module load_tracker
  import pairing_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd_valid,
  input  decoded_t upd_dec,
  output reg_ref_t pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= '0;
    else if (upd_valid && upd_dec.cls == CLS_LOAD)
      pend <= upd_dec.dst;
    else
      pend <= '0;
  end

  // R7: a record exists only in the cycle right after a load issued
  assert_record_follows_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend.vld |-> $past(upd_valid));
endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import pairing_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pkt_valid,
  input  logic     held,
  input  decoded_t dec_lo,
  input  decoded_t dec_hi,
  input  reg_ref_t pend,
  output logic     go_first,
  output logic     go_second,
  output logic     consume
);
  decoded_t first_dec;
  logic     slot_legal, same_pkt_dep, second_ok;

  assign first_dec    = held ? dec_hi : dec_lo;
  assign slot_legal   = (dec_lo.cls != CLS_FPOP) && (dec_hi.cls == CLS_FPOP);
  assign same_pkt_dep = reads_reg(dec_hi, dec_lo.dst) || same_reg(dec_hi.dst, dec_lo.dst);
  assign second_ok    = slot_legal && !same_pkt_dep && !reads_reg(dec_hi, pend);

  assign go_first  = pkt_valid && !reads_reg(first_dec, pend);
  assign go_second = go_first && !held && second_ok;
  assign consume   = held ? go_first : go_second;

  // R7: the issued instruction never consumes the recorded load destination
  assert_no_load_use_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_first |-> !reads_reg(first_dec, pend));

  // R3: the right port only ever carries FP arithmetic beside non-FP work
  assert_right_slot_fp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_second |-> (dec_hi.cls == CLS_FPOP && dec_lo.cls != CLS_FPOP));

  // R6: a paired right instruction is independent of the left destination
  assert_pair_independent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_second |-> !reads_reg(dec_hi, dec_lo.dst));
endmodule

// File: rtl/dual_slot_issue_gate.sv
module dual_slot_issue_gate
  import pairing_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_valid,
  output logic               pkt_ready,
  input  logic [PKT_W-1:0]   pkt_data,
  output logic               fetch_hold,
  output logic               left_go,
  output logic [INSTR_W-1:0] left_instr,
  output logic               right_go,
  output logic [INSTR_W-1:0] right_instr
);
  logic [INSTR_W-1:0] lane_instr [NUM_SLOTS];
  decoded_t           lane_dec   [NUM_SLOTS];
  reg_ref_t           pend;
  logic               held;
  logic               go_first, go_second, consume;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
    assign lane_instr[g] = pkt_data[g*INSTR_W +: INSTR_W];
    slot_decode u_dec (.instr(lane_instr[g]), .dec(lane_dec[g]));
  end

  pair_rules u_rules (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .held(held),
    .dec_lo(lane_dec[0]), .dec_hi(lane_dec[1]), .pend(pend),
    .go_first(go_first), .go_second(go_second), .consume(consume)
  );

  load_tracker u_track (
    .clk(clk), .rst_n(rst_n), .upd_valid(go_first),
    .upd_dec(held ? lane_dec[1] : lane_dec[0]), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held <= 1'b0;
    else if (held && go_first)
      held <= 1'b0;
    else if (!held && go_first && !go_second)
      held <= 1'b1;
  end

  assign left_go     = go_first;
  assign right_go    = go_second;
  assign left_instr  = held ? lane_instr[1] : lane_instr[0];
  assign right_instr = lane_instr[1];
  assign pkt_ready   = consume;
  assign fetch_hold  = pkt_valid && !consume;

  // R4: the right port needs the left port in the same cycle
  assert_pair_needs_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    right_go |-> left_go);

  // R9: no packet, no issue and no acceptance
  assert_idle_without_packet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (!left_go && !pkt_ready));

  // R9: a partly issued packet stays offered until it is taken
  assert_leftover_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> pkt_valid);

  // R5: a leftover issues alone and releases the packet
  assert_leftover_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && left_go) |-> (pkt_ready && !right_go));
endmodule

// File: tb/dual_slot_issue_gate_test.sv
module dual_slot_issue_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt_data = '0;
  logic        pkt_ready, fetch_hold, left_go, right_go;
  logic [31:0] left_instr, right_instr;
  int          n_checks = 0;
  int          n_errors = 0;

  always #5 clk = ~clk;

  dual_slot_issue_gate uut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .fetch_hold(fetch_hold), .left_go(left_go),
    .left_instr(left_instr), .right_go(right_go), .right_instr(right_instr)
  );

  localparam logic [5:0] OP_ALU = 6'b000000, OP_LDI = 6'b010000, OP_LDF = 6'b011000,
                         OP_STI = 6'b100000, OP_STF = 6'b101000, OP_FOP = 6'b110000;

  function automatic logic [31:0] mk(logic [5:0] op, int rd, int s1, int s2);
    return {op, rd[4:0], s1[4:0], s2[4:0], 11'd0};
  endfunction

  // reference decode: {valid, fp file, index}
  function automatic logic [6:0] m_dst(logic [31:0] i);
    case (i[31:30])
      2'b00:   return {2'b10, i[25:21]};
      2'b01:   return {1'b1, i[29], i[25:21]};
      2'b10:   return 7'd0;
      default: return {2'b11, i[25:21]};
    endcase
  endfunction
  function automatic logic [6:0] m_s1(logic [31:0] i);
    return {1'b1, i[31:30] == 2'b11, i[20:16]};
  endfunction
  function automatic logic [6:0] m_s2(logic [31:0] i);
    case (i[31:30])
      2'b00:   return {2'b10, i[15:11]};
      2'b01:   return 7'd0;
      2'b10:   return {1'b1, i[29], i[15:11]};
      default: return {2'b11, i[15:11]};
    endcase
  endfunction
  function automatic logic m_uses(logic [31:0] i, logic [6:0] r);
    logic [6:0] a, b;
    a = m_s1(i);
    b = m_s2(i);
    return r[6] && ((a[6] && a == r) || (b[6] && b == r));
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(logic v, logic [63:0] p, logic eL, logic eR, logic eRdy,
                     logic [31:0] eLi, string tag);
    @(posedge clk);
    #1;
    pkt_valid = v;
    pkt_data  = p;
    @(negedge clk);
    chk(tag, "left_go", {31'd0, left_go}, {31'd0, eL});
    chk(tag, "right_go", {31'd0, right_go}, {31'd0, eR});
    chk(tag, "pkt_ready", {31'd0, pkt_ready}, {31'd0, eRdy});
    chk(tag, "fetch_hold", {31'd0, fetch_hold}, {31'd0, v & ~eRdy});
    if (eL) chk(tag, "left_instr", left_instr, eLi);
    if (eR) chk(tag, "right_instr", right_instr, p[63:32]);
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, nothing offered
    chk("R1", "left_go", {31'd0, left_go}, 32'd0);
    chk("R1", "pkt_ready", {31'd0, pkt_ready}, 32'd0);
    cyc(1'b0, '0, 0, 0, 0, 0, "R9");

    // R3: integer plus independent FP op
    a = mk(OP_ALU, 1, 2, 3); b = mk(OP_FOP, 3, 1, 2);
    cyc(1, {b, a}, 1, 1, 1, a, "R3");
    // R2: integer load r5 vs FP regs 5..7 are different files
    a = mk(OP_LDI, 5, 1, 0); b = mk(OP_FOP, 5, 6, 7);
    cyc(1, {b, a}, 1, 1, 1, a, "R2");
    // R7 / R4: left reads r5 -> nothing issues; next cycle record gone
    a = mk(OP_ALU, 6, 5, 0); b = mk(OP_FOP, 1, 2, 3);
    cyc(1, {b, a}, 0, 0, 0, 0, "R4");
    cyc(1, {b, a}, 1, 1, 1, a, "R7");
    // R6: right reads FP-load destination; leftover then load-use stalled
    a = mk(OP_LDF, 4, 1, 0); b = mk(OP_FOP, 8, 4, 1);
    cyc(1, {b, a}, 1, 0, 0, a, "R6");
    cyc(1, {b, a}, 0, 0, 0, 0, "R7");
    cyc(1, {b, a}, 1, 0, 1, b, "R5");
    // R8: FP load pairs with independent FP op
    a = mk(OP_LDF, 9, 1, 0); b = mk(OP_FOP, 10, 11, 12);
    cyc(1, {b, a}, 1, 1, 1, a, "R8");
    // R7: right reads f9 loaded last cycle -> split, leftover issues next
    a = mk(OP_ALU, 1, 2, 3); b = mk(OP_FOP, 13, 9, 1);
    cyc(1, {b, a}, 1, 0, 0, a, "R7");
    cyc(1, {b, a}, 1, 0, 1, b, "R7");
    // R5: FP op in left slot
    a = mk(OP_FOP, 1, 2, 3); b = mk(OP_FOP, 4, 5, 6);
    cyc(1, {b, a}, 1, 0, 0, a, "R5");
    cyc(1, {b, a}, 1, 0, 1, b, "R5");
    // R5: non-FP in right slot
    a = mk(OP_ALU, 1, 2, 3); b = mk(OP_ALU, 4, 5, 6);
    cyc(1, {b, a}, 1, 0, 0, a, "R5");
    cyc(1, {b, a}, 1, 0, 1, b, "R5");
    // R10: FP store rd field 14 is not a destination
    a = mk(OP_STF, 14, 1, 15); b = mk(OP_FOP, 16, 14, 1);
    cyc(1, {b, a}, 1, 1, 1, a, "R10");
    // R6: same destination f20 splits the pair
    a = mk(OP_LDF, 20, 1, 0); b = mk(OP_FOP, 20, 1, 2);
    cyc(1, {b, a}, 1, 0, 0, a, "R6");
    cyc(1, {b, a}, 1, 0, 1, b, "R6");
    // R2: same index in different files
    a = mk(OP_ALU, 7, 7, 7); b = mk(OP_FOP, 7, 7, 7);
    cyc(1, {b, a}, 1, 1, 1, a, "R2");
    // R2: integer store rd field is not a destination
    a = mk(OP_STI, 3, 1, 2); b = mk(OP_FOP, 3, 3, 3);
    cyc(1, {b, a}, 1, 1, 1, a, "R2");
    cyc(0, '0, 0, 0, 0, 0, "R9");

    // random streams against the reference model
    begin
      logic        m_held, v, eL, eR, eRdy;
      logic [6:0]  m_pend;
      logic [63:0] p;
      logic [31:0] first;
      logic [5:0]  ops [6];
      ops[0] = OP_ALU; ops[1] = OP_LDI; ops[2] = OP_LDF;
      ops[3] = OP_STI; ops[4] = OP_STF; ops[5] = OP_FOP;
      m_held = 0; m_pend = 0; v = 0; p = '0; eRdy = 0;
      for (int n = 0; n < 6000; n++) begin
        @(posedge clk);
        #1;
        if (!(v && !eRdy) || !v) begin
          if (!(v && !eRdy)) begin
            v = ($urandom % 8) != 0;
            p = {mk(ops[$urandom % 6], $urandom % 4, $urandom % 4, $urandom % 4),
                 mk(ops[$urandom % 6], $urandom % 4, $urandom % 4, $urandom % 4)};
          end
        end
        pkt_valid = v;
        pkt_data  = p;
        first = m_held ? p[63:32] : p[31:0];
        eL = v && !m_uses(first, m_pend);
        eR = eL && !m_held && p[31:30] != 2'b11 && p[63:62] == 2'b11 &&
             !m_uses(p[63:32], m_pend) && !m_uses(p[63:32], m_dst(p[31:0])) &&
             !(m_dst(p[31:0])[6] && m_dst(p[63:32]) == m_dst(p[31:0]));
        eRdy = m_held ? eL : eR;
        @(negedge clk);
        chk("R7", "left_go", {31'd0, left_go}, {31'd0, eL});
        chk("R3", "right_go", {31'd0, right_go}, {31'd0, eR});
        chk("R9", "pkt_ready", {31'd0, pkt_ready}, {31'd0, eRdy});
        if (eL) chk("R5", "left_instr", left_instr, first);
        m_pend = (eL && first[31:30] == 2'b01) ? m_dst(first) : 7'd0;
        if (m_held && eL) m_held = 0;
        else if (!m_held && eL && !eR) m_held = 1;
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule